// File: doc/BRIEF.md
# Two-Rate Radar Test Pulse Generator

This block makes two periodic test pulse trains from one system clock, a fast train and a slow train. The nominal system clock is 10 MHz, so one clock is 100 ns.

The fast train is built in two stages. A period divider emits a one-clock tick. A shaping stage then turns that tick into a pulse: the tick sets an output flag, and a width counter clears the flag after a fixed number of clocks. The width counter stays at zero while the flag is low. With the default values the fast train has a 6 µs period and a 1.2 µs high time.

The slow train has no period divider on the system clock. Instead it counts the fast train's ticks, and every tenth one starts a 3 µs pulse, which gives a 60 µs period. A synchronous hold input forces both outputs low and clears every counter. An outside gating signal can therefore restart both trains from a known phase.

Top module: `radar_prf_gen`

## Requirements
- R1: While rst_n is low, and on the first clock after it is released, hrr_out and mrr_out are both 0.
- R2: After a restart, hrr_out rises once every HRR_PERIOD clocks for as long as hold_clear stays low.
- R3: Each hrr_out pulse is high for exactly HRR_WIDTH_MOD-1 consecutive clocks (12 by default).
- R4: Every complete hrr_out pulse has the same width. No count carries over from one pulse to the next, because the width counter rests at zero between pulses.
- R5: mrr_out rises once every HRR_PERIOD*MRR_DIV clocks, and always on the same clock as an hrr_out rise.
- R6: Each mrr_out pulse is high for exactly MRR_HIGH consecutive clocks (30 by default). This holds even when the pulse spans several hrr_out pulses.
- R7: On the clock after any cycle in which hold_clear is 1, both outputs are 0. This includes a hold that arrives in the middle of a pulse.
- R8: A restart is either reset release or the first clock with hold_clear at 0. Counting the clocks with hold_clear at 0 from the restart as 1, 2, 3 and so on, the first hrr_out rise appears on clock HRR_PERIOD. The first mrr_out rise appears on clock HRR_PERIOD*MRR_DIV.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_clear | input | 1 | Synchronous hold: clears all counters and forces both outputs low |
| hrr_out | output | 1 | High repetition rate pulse train |
| mrr_out | output | 1 | Medium repetition rate pulse train |

## Verification
The bench scales the block down so that each train repeats within a few dozen clocks:
- HRR_PERIOD = 8
- HRR_WIDTH_MOD = 4, which gives a 3-clock fast pulse
- MRR_DIV = 3
- MRR_HIGH = 10

With these values many fast and slow periods fit into a short run. The 10-clock slow pulse is longer than the 8-clock fast period, so it spans a second fast pulse, which the default values never show. Holds are placed in the middle of a fast pulse and a slow pulse at the same time, and one single-cycle hold is included. Together these exercise the abort and the phase-aligned restart of both trains.

// File: rtl/radar_prf_pkg.sv
package radar_prf_pkg;

  // Register width needed to hold the values 0 .. m-1 (at least one bit).
  function automatic int cnt_w(input int m);
    if (m <= 2) return 1;
    return $clog2(m);
  endfunction

  // The width counter modulus includes the wrap clock, so the high time is one less.
  function automatic int high_clks(input int width_mod);
    return width_mod - 1;
  endfunction

  // Period of the slow train, in system clocks.
  function automatic int slow_period(input int fast_period, input int div);
    return fast_period * div;
  endfunction

endpackage

// File: rtl/prf_period_div.sv
module prf_period_div
  import radar_prf_pkg::*;
#(
  parameter int MOD = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic tick
);
  localparam int W = cnt_w(MOD);
  localparam logic [W-1:0] LAST = W'(MOD - 1);

  logic [W-1:0] cnt;

  assign tick = en && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (en) begin
      if (tick) cnt <= '0;
      else      cnt <= cnt + 1'b1;
    end
  end

  AST_TICK_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr) |=> (cnt == '0)); // R2

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST); // R5

endmodule

// File: rtl/prf_pulse_shaper.sv
module prf_pulse_shaper
  import radar_prf_pkg::*;
#(
  parameter int HIGH_CLKS = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic pulse
);
  localparam int W = cnt_w(HIGH_CLKS);
  localparam logic [W-1:0] LAST = W'(HIGH_CLKS - 1);

  logic         flag;
  logic [W-1:0] wcnt;
  logic         width_end;

  assign width_end = flag && (wcnt == LAST);
  assign pulse     = flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      wcnt <= '0;
    end else if (clr) begin
      flag <= 1'b0;
      wcnt <= '0;
    end else if (tick) begin
      flag <= 1'b1;
      wcnt <= '0;
    end else if (width_end) begin
      flag <= 1'b0;
      wcnt <= '0;
    end else if (flag) begin
      wcnt <= wcnt + 1'b1;
    end else begin
      wcnt <= '0;
    end
  end

  AST_TICK_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr) |=> flag); // R2

  AST_RISE_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(tick)); // R2

  AST_WIDTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    flag |-> (wcnt <= LAST)); // R3

  AST_IDLE_COUNTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !flag |-> (wcnt == '0)); // R4

endmodule

// File: rtl/radar_prf_gen.sv
module radar_prf_gen
  import radar_prf_pkg::*;
#(
  parameter int HRR_PERIOD    = 60,
  parameter int HRR_WIDTH_MOD = 13,
  parameter int MRR_DIV       = 10,
  parameter int MRR_HIGH      = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_clear,
  output logic hrr_out,
  output logic mrr_out
);
  localparam int HRR_HIGH = high_clks(HRR_WIDTH_MOD);
  localparam int MRR_PER  = slow_period(HRR_PERIOD, MRR_DIV);

  logic hrr_tick;
  logic mrr_tick;

  prf_period_div #(.MOD(HRR_PERIOD)) u_hrr_div (
    .clk(clk), .rst_n(rst_n), .clr(hold_clear), .en(1'b1), .tick(hrr_tick)
  );

  prf_pulse_shaper #(.HIGH_CLKS(HRR_HIGH)) u_hrr_shape (
    .clk(clk), .rst_n(rst_n), .clr(hold_clear), .tick(hrr_tick), .pulse(hrr_out)
  );

  // The slow divider advances only on fast-train ticks.
  prf_period_div #(.MOD(MRR_DIV)) u_mrr_div (
    .clk(clk), .rst_n(rst_n), .clr(hold_clear), .en(hrr_tick), .tick(mrr_tick)
  );

  prf_pulse_shaper #(.HIGH_CLKS(MRR_HIGH)) u_mrr_shape (
    .clk(clk), .rst_n(rst_n), .clr(hold_clear), .tick(mrr_tick), .pulse(mrr_out)
  );

  initial begin
    assert (HRR_HIGH >= 1 && HRR_HIGH < HRR_PERIOD);
    assert (MRR_HIGH >= 1 && MRR_HIGH < MRR_PER);
  end

  AST_HOLD_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    hold_clear |=> (!hrr_out && !mrr_out)); // R7

  AST_MRR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mrr_out) |-> $rose(hrr_out)); // R5

  AST_MRR_ON_FAST_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    mrr_tick |-> hrr_tick); // R5

endmodule

// File: tb/radar_prf_gen_test.sv
module radar_prf_gen_test;
  localparam int P  = 8;
  localparam int WM = 4;
  localparam int HW = WM - 1;
  localparam int D  = 3;
  localparam int MW = 10;
  localparam int P2 = P * D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hold_clear = 1'b0;
  logic hrr_out, mrr_out;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  radar_prf_gen #(.HRR_PERIOD(P), .HRR_WIDTH_MOD(WM), .MRR_DIV(D), .MRR_HIGH(MW)) uut (
    .clk(clk), .rst_n(rst_n), .hold_clear(hold_clear), .hrr_out(hrr_out), .mrr_out(mrr_out)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Reference: k counts the clock edges since the last restart (reset or hold).
  int k = 0;
  bit h_restart = 1, m_restart = 1;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || hold_clear) begin
      k = 0; h_restart = 1; m_restart = 1;
    end else begin
      k = k + 1;
    end
  end

  bit checking = 0;
  bit ph = 0, pm = 0;
  int h_len = 0, m_len = 0, h_last = 0, m_last = 0, first_w = -1;
  always @(negedge clk) begin
    if (checking) begin
      bit eh, em;
      eh = (k >= P)  && ((k % P)  < HW);
      em = (k >= P2) && ((k % P2) < MW);
      if (k == 0) begin
        check(hrr_out == 1'b0, rst_n ? "R7" : "R1", "hrr_out after restart", hrr_out, 0);
        check(mrr_out == 1'b0, rst_n ? "R7" : "R1", "mrr_out after restart", mrr_out, 0);
      end else begin
        check(hrr_out == eh, "R2", "hrr_out per-cycle", hrr_out, eh);
        check(mrr_out == em, "R5", "mrr_out per-cycle", mrr_out, em);
      end
      if (hrr_out && !ph) begin
        if (h_restart) check(k == P, "R8", "first hrr rise clock", k, P);
        else           check(k - h_last == P, "R2", "hrr rise interval", k - h_last, P);
        h_restart = 0; h_last = k; h_len = 0;
      end
      if (mrr_out && !pm) begin
        check(hrr_out && !ph, "R5", "mrr rise aligned to hrr rise", hrr_out, 1);
        if (m_restart) check(k == P2, "R8", "first mrr rise clock", k, P2);
        else           check(k - m_last == P2, "R5", "mrr rise interval", k - m_last, P2);
        m_restart = 0; m_last = k; m_len = 0;
      end
      if (hrr_out) h_len++;
      if (mrr_out) m_len++;
      if (!hrr_out && ph && k != 0) begin
        check(h_len == HW, "R3", "hrr width", h_len, HW);
        if (first_w < 0) first_w = h_len;
        check(h_len == first_w, "R4", "hrr width repeat", h_len, first_w);
      end
      if (!mrr_out && pm && k != 0)
        check(m_len == MW, "R6", "mrr width", m_len, MW);
      ph = hrr_out; pm = mrr_out;
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    checking = 1;
    run(3);
    check(hrr_out == 1'b0 && mrr_out == 1'b0, "R1", "outputs in reset", {hrr_out, mrr_out}, 0);
    rst_n = 1'b1;
    run(80);
    check(hrr_out == 1'b1 && mrr_out == 1'b1, "R7", "both high before mid-pulse hold", {hrr_out, mrr_out}, 3);
    hold_clear = 1'b1;
    run(4);
    hold_clear = 1'b0;
    run(60);
    hold_clear = 1'b1;
    run(1);
    hold_clear = 1'b0;
    run(100);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule